// File: doc/BRIEF.md
# Transaction-Aware Chunk Recorder

This block watches one core and cuts its execution into chunks. A chunk is a run of retired instructions during which no conflicting remote access and no system event occurred. While a chunk is open, every local read and write is hashed into one of two Bloom filters: a read set or a write set. Each coherence snoop from another core is tested against both filters in the same cycle. If the snoop conflicts with them, the chunk is closed.

Hardware transactions move the chunk boundaries. A transaction begin, commit or abort closes the running chunk. An abort also carries its 8-bit status code into the log. Every closed chunk produces one record. The record holds:
- the instruction count of the chunk,
- a 3-bit reason code,
- the abort status,
- a global timestamp, so that records from several cores can be merged into one order later.

Records wait in a small in-order queue. They leave it over a valid/ready handshake.

Top module: `chunk_rec`

## Requirements
- R1: After reset, `logValid` and `inTx` are 0. The timestamp counter restarts from 0.
- R2: A record's count is the number of cycles with `retireValid` high since the chunk opened, not including the cycle that closes the chunk. An instruction that retires in the closing cycle is counted in the next chunk.
- R3: When the running count equals its all-ones maximum, that cycle closes the chunk. The record has reason 5 and the maximum count.
- R4: A snoop closes the chunk with reason 0 in two cases: a remote write whose line tests present in the read set or the write set, or a remote read whose line tests present in the write set. A remote read that only matches the read set has no effect.
- R5: A line tests present when both of its filter bits are set. With the line split into halves `hi` and `lo`, the bit positions are `lo` and `hi XOR (lo with its two nibble-halves swapped)`. Two distinct lines that map to the same pair therefore alias: with `hi` = 0, line 0x21 is present once line 0x12 has been written.
- R6: Every chunk closure empties both filters. A local access made in the closing cycle is entered into the new chunk. A snoop is tested against the filter contents from before the current cycle's insertions.
- R7: `txBegin` closes the chunk with reason 2 and raises `inTx`.
- R8: `txCommit` closes the chunk with reason 3 and lowers `inTx`.
- R9: `txAbort` closes the chunk with reason 4, copies `abortCode` into `logStatus` and lowers `inTx`. Every other reason carries status 0.
- R10: `sysEvent` closes the chunk with reason 1.
- R11: Each cycle closes at most one chunk. When several causes coincide, the reason is chosen in the order abort, commit, begin, system event, conflict, overflow. `inTx` is lowered whenever commit or abort is present.
- R12: A record's stamp is the number of clock edges since reset released, taken in the closing cycle.
- R13: Records are delivered in closing order. With an empty queue, a record is visible one cycle after its closing cycle. While `logReady` is low, `logValid` and the record fields hold, and up to DEPTH records wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| retireValid | input | 1 | One instruction retired this cycle |
| memValid | input | 1 | Local memory access this cycle |
| memWrite | input | 1 | Local access is a write (else a read) |
| memLine | input | LINE_W | Cache-line address of the local access |
| snoopValid | input | 1 | Remote coherence snoop this cycle |
| snoopWrite | input | 1 | Snoop is for a remote write (else a read) |
| snoopLine | input | LINE_W | Cache-line address of the snoop |
| sysEvent | input | 1 | System event (interrupt, trap) this cycle |
| txBegin | input | 1 | Hardware transaction starts |
| txCommit | input | 1 | Hardware transaction commits |
| txAbort | input | 1 | Hardware transaction aborts |
| abortCode | input | 8 | Abort status accompanying `txAbort` |
| logReady | input | 1 | Consumer accepts the head record |
| logValid | output | 1 | A record is presented |
| logCount | output | CW | Instructions in the closed chunk |
| logReason | output | 3 | 0 conflict, 1 system, 2 begin, 3 commit, 4 abort, 5 overflow |
| logStatus | output | 8 | Abort status, 0 for other reasons |
| logStamp | output | TW | Global timestamp of the closure |
| inTx | output | 1 | A hardware transaction is open |

## Verification
The design has one register stage from a stimulus cycle to any result. A closure decided in cycle t is written into the queue at the edge that ends t. With an empty queue, the record is therefore visible in cycle t+1. `inTx` changes on that same edge.

The bench applies each stimulus just after a falling edge. It predicts the record at that moment from the requirements and pushes it into a scoreboard queue. It checks `inTx` before the next stimulus is applied.

A monitor samples one nanosecond after each falling edge, well clear of the rising edge. It pops and compares a record only in cycles where both valid and ready are high. This keeps the comparisons correct under backpressure and when records queue up.

// File: rtl/chunk_rec_pkg.sv
package chunk_rec_pkg;

  typedef enum logic [2:0] {
    RS_CONFLICT = 3'd0,
    RS_SYSTEM   = 3'd1,
    RS_TXBEGIN  = 3'd2,
    RS_TXCOMMIT = 3'd3,
    RS_TXABORT  = 3'd4,
    RS_OVERFLOW = 3'd5
  } termReason_e;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic        term;
    termReason_e why;
  } ctrlStrobe_t;

endpackage

// File: rtl/chunk_rec_ctrl.sv
module chunk_rec_ctrl
  import chunk_rec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txBegin,
  input  logic        txCommit,
  input  logic        txAbort,
  input  logic        sysEvent,
  input  logic        snoopHit,
  input  logic        cntFull,
  output ctrlStrobe_t strobe,
  output logic        inTx
);

  // fixed priority of closure causes (R11)
  always_comb begin
    strobe.term = 1'b1;
    strobe.why  = RS_CONFLICT;
    if (txAbort)       strobe.why = RS_TXABORT;
    else if (txCommit) strobe.why = RS_TXCOMMIT;
    else if (txBegin)  strobe.why = RS_TXBEGIN;
    else if (sysEvent) strobe.why = RS_SYSTEM;
    else if (snoopHit) strobe.why = RS_CONFLICT;
    else if (cntFull)  strobe.why = RS_OVERFLOW;
    else               strobe.term = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     inTx <= 1'b0;
    else if (txAbort || txCommit)  inTx <= 1'b0;
    else if (txBegin)              inTx <= 1'b1;
  end

  p_begin_opens_r7: assert property (@(posedge clk) disable iff (!rstN)
    txBegin && !txCommit && !txAbort |=> inTx);

  p_end_closes_r8: assert property (@(posedge clk) disable iff (!rstN)
    txCommit || txAbort |=> !inTx);

  p_full_closes_r3: assert property (@(posedge clk) disable iff (!rstN)
    cntFull |-> strobe.term);

  p_abort_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> strobe.why == RS_TXABORT);

endmodule

// File: rtl/chunk_rec_dp.sv
module chunk_rec_dp
  import chunk_rec_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int CW     = 16,
  parameter int TW     = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              retireValid,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [LINE_W-1:0] memLine,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic [7:0]        abortCode,
  input  logic              logReady,
  output logic              snoopHit,
  output logic              cntFull,
  output logic              logValid,
  output logic [CW-1:0]     logCount,
  output logic [2:0]        logReason,
  output logic [7:0]        logStatus,
  output logic [TW-1:0]     logStamp
);

  localparam int FB   = LINE_W / 2;       // filter index width
  localparam int HB   = FB / 2;
  localparam int NB   = 1 << FB;          // bits per filter
  localparam int PW   = $clog2(DEPTH);
  localparam int RW   = CW + 3 + 8 + TW;

  function automatic logic [NB-1:0] lineMask(input logic [LINE_W-1:0] ln);
    logic [FB-1:0] lo, h1;
    lo = ln[FB-1:0];
    h1 = ln[LINE_W-1:FB] ^ {lo[HB-1:0], lo[FB-1:HB]};
    return ({{(NB-1){1'b0}}, 1'b1} << lo) | ({{(NB-1){1'b0}}, 1'b1} << h1);
  endfunction

  logic [NB-1:0] rsBits, wsBits, snMask, memMask;
  logic          rsHit, wsHit;

  always_comb begin
    snMask   = lineMask(snoopLine);
    memMask  = lineMask(memLine);
    rsHit    = (snMask & rsBits) == snMask;
    wsHit    = (snMask & wsBits) == snMask;
    snoopHit = snoopValid && (wsHit || (snoopWrite && rsHit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsBits <= '0;
      wsBits <= '0;
    end else begin
      rsBits <= (strobe.term ? '0 : rsBits) | ((memValid && !memWrite) ? memMask : '0);
      wsBits <= (strobe.term ? '0 : wsBits) | ((memValid &&  memWrite) ? memMask : '0);
    end
  end

  logic [CW-1:0] chunkCnt;
  logic [TW-1:0] stampCnt;
  assign cntFull = chunkCnt == '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chunkCnt <= '0;
      stampCnt <= '0;
    end else begin
      chunkCnt <= (strobe.term ? '0 : chunkCnt) + CW'(retireValid);
      stampCnt <= stampCnt + 1'b1;
    end
  end

  // in-order record queue
  logic [RW-1:0] recQ [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [PW:0]   used;
  logic          push, pop;
  logic [RW-1:0] newRec;

  assign push     = strobe.term && (used != (PW+1)'(DEPTH));
  assign pop      = logValid && logReady;
  assign logValid = used != '0;
  assign newRec   = {chunkCnt, strobe.why,
                     (strobe.why == RS_TXABORT) ? abortCode : 8'h00, stampCnt};
  assign {logCount, logReason, logStatus, logStamp} = recQ[rdPtr];

  always_ff @(posedge clk) begin
    if (push) recQ[wrPtr] <= newRec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      used <= used + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  p_count_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.term |=> chunkCnt == CW'($past(retireValid)));

  p_filters_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.term && !memValid |=> rsBits == '0 && wsBits == '0);

  p_stamp_steps_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> stampCnt == $past(stampCnt) + 1'b1);

  p_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    logValid && !logReady |=> logValid && $stable(logCount) && $stable(logReason)
                              && $stable(logStatus) && $stable(logStamp));

endmodule

// File: rtl/chunk_rec.sv
module chunk_rec
  import chunk_rec_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int CW     = 16,
  parameter int TW     = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [LINE_W-1:0] memLine,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              sysEvent,
  input  logic              txBegin,
  input  logic              txCommit,
  input  logic              txAbort,
  input  logic [7:0]        abortCode,
  input  logic              logReady,
  output logic              logValid,
  output logic [CW-1:0]     logCount,
  output logic [2:0]        logReason,
  output logic [7:0]        logStatus,
  output logic [TW-1:0]     logStamp,
  output logic              inTx
);

  ctrlStrobe_t strobe;
  logic        snoopHit, cntFull;

  chunk_rec_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .txBegin(txBegin), .txCommit(txCommit), .txAbort(txAbort),
    .sysEvent(sysEvent), .snoopHit(snoopHit), .cntFull(cntFull),
    .strobe(strobe), .inTx(inTx)
  );

  chunk_rec_dp #(.LINE_W(LINE_W), .CW(CW), .TW(TW), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .retireValid(retireValid),
    .memValid(memValid), .memWrite(memWrite), .memLine(memLine),
    .snoopValid(snoopValid), .snoopWrite(snoopWrite), .snoopLine(snoopLine),
    .abortCode(abortCode), .logReady(logReady),
    .snoopHit(snoopHit), .cntFull(cntFull),
    .logValid(logValid), .logCount(logCount), .logReason(logReason),
    .logStatus(logStatus), .logStamp(logStamp)
  );

endmodule

// File: tb/sim_chunk_rec.sv
`timescale 1ns/1ps
module sim_chunk_rec;

  localparam int LINE_W = 16;
  localparam int CW     = 6;
  localparam int TW     = 16;
  localparam int DEPTH  = 4;
  localparam int MAXC   = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, retireValid, memValid, memWrite, snoopValid, snoopWrite;
  logic sysEvent, txBegin, txCommit, txAbort, logReady;
  logic [LINE_W-1:0] memLine, snoopLine;
  logic [7:0] abortCode;
  logic logValid, inTx;
  logic [CW-1:0] logCount;
  logic [2:0] logReason;
  logic [7:0] logStatus;
  logic [TW-1:0] logStamp;

  chunk_rec #(.LINE_W(LINE_W), .CW(CW), .TW(TW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .retireValid(retireValid),
    .memValid(memValid), .memWrite(memWrite), .memLine(memLine),
    .snoopValid(snoopValid), .snoopWrite(snoopWrite), .snoopLine(snoopLine),
    .sysEvent(sysEvent), .txBegin(txBegin), .txCommit(txCommit), .txAbort(txAbort),
    .abortCode(abortCode), .logReady(logReady),
    .logValid(logValid), .logCount(logCount), .logReason(logReason),
    .logStatus(logStatus), .logStamp(logStamp), .inTx(inTx)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  typedef struct { int cnt; int why; int st; int stamp; } rec_t;
  rec_t expQ[$];

  int       mCnt = 0;
  bit [255:0] mRs = '0, mWs = '0;
  bit       mTx = 0, rdy = 1;

  // filter bit pair of a line whose upper half is zero (R5)
  function automatic bit [255:0] hmask(input logic [7:0] ln);
    bit [255:0] m;
    logic [7:0] h1;
    h1 = {ln[3:0], ln[7:4]};
    m = '0;
    m[ln] = 1'b1;
    m[h1] = 1'b1;
    return m;
  endfunction

  function automatic string tagOf(input int why);
    case (why)
      0: return "R4";
      1: return "R10";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R3";
    endcase
  endfunction

  // ev = {abort, commit, begin, sys}
  task automatic step(input bit r, input bit mv, input bit mw, input logic [7:0] ma,
                      input bit sv, input bit sw, input logic [7:0] sa,
                      input bit [3:0] ev, input logic [7:0] code);
    bit [255:0] sm;
    bit hit, term;
    int why;
    @(negedge clk);
    checks++;
    if (inTx !== mTx) begin
      fails++;
      $display("FAIL R7/R8 inTx: actual %0d expected %0d", inTx, mTx);
    end
    retireValid = r; memValid = mv; memWrite = mw; memLine = {8'h00, ma};
    snoopValid = sv; snoopWrite = sw; snoopLine = {8'h00, sa};
    txAbort = ev[3]; txCommit = ev[2]; txBegin = ev[1]; sysEvent = ev[0];
    abortCode = code; logReady = rdy;
    sm  = hmask(sa);
    hit = sv && (((sm & mWs) == sm) || (sw && ((sm & mRs) == sm)));
    term = 1'b1;
    if (ev[3])            why = 4;
    else if (ev[2])       why = 3;
    else if (ev[1])       why = 2;
    else if (ev[0])       why = 1;
    else if (hit)         why = 0;
    else if (mCnt == MAXC) why = 5;
    else begin why = 0; term = 1'b0; end
    if (term) begin
      expQ.push_back('{mCnt, why, (why == 4) ? int'(code) : 0, cyc % (1 << TW)});
      mCnt = int'(r); mRs = '0; mWs = '0;
    end else begin
      mCnt = mCnt + int'(r);
    end
    if (mv) begin
      if (mw) mWs |= hmask(ma);
      else    mRs |= hmask(ma);
    end
    if (ev[3] || ev[2]) mTx = 1'b0;
    else if (ev[1])     mTx = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0000, 8'h00);
  endtask

  task automatic retire(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0000, 8'h00);
  endtask

  // scoreboard monitor, samples 1 ns after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (rstN && !finished && logValid && logReady) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R13 unexpected record: actual reason %0d expected none", logReason);
      end else begin
        rec_t e;
        e = expQ.pop_front();
        checks++;
        if (int'(logCount) != e.cnt || int'(logReason) != e.why || int'(logStatus) != e.st) begin
          fails++;
          $display("FAIL %s/R2 record: actual cnt=%0d why=%0d st=%0h expected cnt=%0d why=%0d st=%0h",
                   tagOf(e.why), logCount, logReason, logStatus, e.cnt, e.why, e.st);
        end
        checks++;
        if (int'(logStamp) != e.stamp) begin
          fails++;
          $display("FAIL R12 stamp: actual %0d expected %0d", logStamp, e.stamp);
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    rstN = 0; retireValid = 0; memValid = 0; memWrite = 0; memLine = '0;
    snoopValid = 0; snoopWrite = 0; snoopLine = '0; sysEvent = 0;
    txBegin = 0; txCommit = 0; txAbort = 0; abortCode = 0; logReady = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state
    #1;
    checks++;
    if (logValid !== 1'b0) begin fails++; $display("FAIL R1 logValid: actual %0b expected 0", logValid); end
    checks++;
    if (inTx !== 1'b0) begin fails++; $display("FAIL R1 inTx: actual %0b expected 0", inTx); end

    // R2 R10: count then system event, retire in closing cycle goes forward
    retire(5);
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0001, 8'h00);
    retire(2);
    step(0, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0001, 8'h00);

    // R4: remote read hits write set
    step(1, 1, 1, 8'h12, 0, 0, 8'h00, 4'b0000, 8'h00);
    retire(3);
    step(0, 0, 0, 8'h00, 1, 0, 8'h12, 4'b0000, 8'h00);
    // R4: remote read on read set is ignored, remote write on it conflicts
    step(1, 1, 0, 8'h34, 0, 0, 8'h00, 4'b0000, 8'h00);
    step(1, 0, 0, 8'h00, 1, 0, 8'h34, 4'b0000, 8'h00);
    step(1, 0, 0, 8'h00, 1, 1, 8'h34, 4'b0000, 8'h00);

    // R5: aliasing line 0x21 after writing 0x12
    step(0, 1, 1, 8'h12, 0, 0, 8'h00, 4'b0000, 8'h00);
    step(1, 0, 0, 8'h00, 1, 1, 8'h21, 4'b0000, 8'h00);
    step(1, 0, 0, 8'h00, 1, 1, 8'h56, 4'b0000, 8'h00);   // no alias, ignored

    // R6: closure empties filters; closing-cycle access enters new chunk
    step(1, 1, 1, 8'h56, 0, 0, 8'h00, 4'b0000, 8'h00);
    step(1, 1, 1, 8'h78, 0, 0, 8'h00, 4'b0001, 8'h00);
    step(1, 0, 0, 8'h00, 1, 1, 8'h56, 4'b0000, 8'h00);   // gone
    step(1, 0, 0, 8'h00, 1, 1, 8'h78, 4'b0000, 8'h00);   // kept
    // R6: snoop in same cycle as insertion sees old contents
    step(1, 1, 1, 8'h9a, 1, 1, 8'h9a, 4'b0000, 8'h00);
    step(0, 0, 0, 8'h00, 1, 0, 8'h9a, 4'b0000, 8'h00);

    // R7 R9: transaction begin, accesses, abort with status
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0010, 8'h00);
    step(1, 1, 1, 8'h34, 0, 0, 8'h00, 4'b0000, 8'h00);
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b1000, 8'hA5);
    // R7 R8: begin then commit
    step(0, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0010, 8'h00);
    retire(4);
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0100, 8'h00);

    // R11: abort + system + conflict together, one record
    step(0, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0010, 8'h00);
    step(1, 1, 1, 8'h56, 0, 0, 8'h00, 4'b0000, 8'h00);
    step(1, 0, 0, 8'h00, 1, 1, 8'h56, 4'b1001, 8'h3C);
    // R11: commit and begin together, commit wins, inTx low
    step(0, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0010, 8'h00);
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0110, 8'h00);
    idle(2);

    // R3: count overflow
    step(0, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0001, 8'h00);
    retire(MAXC);
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0000, 8'h00);
    step(0, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0001, 8'h00);
    idle(2);

    // R13: backpressure, three records queued and held
    rdy = 0;
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0001, 8'h00);
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b0010, 8'h00);
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 4'b1000, 8'h77);
    idle(3);
    checks++;
    if (logValid !== 1'b1) begin fails++; $display("FAIL R13 stalled logValid: actual %0b expected 1", logValid); end
    checks++;
    if (logReason !== 3'd1) begin fails++; $display("FAIL R13 head held: actual %0d expected 1", logReason); end
    rdy = 1;
    idle(6);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R13 records missing: actual %0d left expected 0", expQ.size());
    end
    finish_run();
  end

endmodule